// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This core supervises software with a watchdog that counts down in two stages, clocked from a fixed reference clock. On the first stage's expiry it raises a one-cycle interrupt pulse. The pulse goes to the general interrupt line, to the system-management line, or nowhere, depending on a type selection. The core then counts a second, independently preloaded interval. If that interval also expires, the core can pulse a reboot request and record a sticky flag. It then either restarts the first stage (free-running operation) or parks in an expired state.

Software keeps the core from expiring by pulsing the keep-alive strobe, which restarts the first stage. A three-bit control word carries enable, free-run and lock. Once lock has been written as 1, later control writes are ignored until reset. The tick rate is selectable: the slow scale divides the reference by 2^15 and the fast scale by 2^5. A stage therefore lasts its preload value times that divisor, in reference cycles. Bus decode, the register unlock sequence and the reset action itself belong to the surrounding logic. There is no streaming data here, so every pin is a plain control or status level or strobe, with no valid/ready handshake.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset `stage_o` is 0, `irq_o`, `smi_o`, `reboot_req_o` and `prev_reboot_o` are low, and the control word is cleared (not enabled, not locked, not free-running). `stage_o` encodes 0 = stopped, 1 = first stage, 2 = second stage, 3 = expired.
- R2: A control write (`ctl_wr_i`) whose bit 1 is 1 while the core is disabled starts stage 1 in the next cycle. Rewriting bit 1 as 1 while already enabled does not restart the count. Writing bit 1 as 0 while unlocked returns `stage_o` to 0, and no pulses follow.
- R3: A stage ends exactly P x 2^5 reference cycles after its start edge when `fast_i` is 1, and P x 2^15 cycles when `fast_i` is 0. P is the stage's preload value; a preload of 0 behaves as 1.
- R4: On stage-1 expiry, `int_type_i` = 0 gives a one-cycle `irq_o` pulse, 2 gives a one-cycle `smi_o` pulse, and 1 or 3 gives neither. In the same cycle `stage_o` becomes 2.
- R5: On stage-2 expiry with `reboot_off_i` = 0, `reboot_req_o` pulses for one cycle and `prev_reboot_o` is set. With `reboot_off_i` = 1, neither happens.
- R6: After stage-2 expiry, `stage_o` becomes 1 and counting restarts if free-run (control bit 2) is set. Otherwise `stage_o` becomes 3 and stays there.
- R7: A `kick_i` pulse while enabled restarts stage 1 from the first preload. While disabled it has no effect, and `stage_o` stays 0.
- R8: A `kick_i` pulse in the same cycle as an expiry wins: no expiry pulse occurs and stage 1 restarts.
- R9: Once a control write sets bit 0 (lock), later control writes change none of enable, free-run or lock until reset.
- R10: `prev_reboot_o` stays set until a `clr_prev_i` pulse clears it.
- R11: Each preload input is sampled when its stage starts. Changing it mid-stage does not alter the running stage's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_word_i | input | 3 | Control word: bit 2 free-run, bit 1 enable, bit 0 lock |
| reboot_off_i | input | 1 | 1 suppresses the reboot request |
| fast_i | input | 1 | 1 selects 2^5 cycles per tick, 0 selects 2^15 |
| int_type_i | input | 2 | Stage-1 interrupt type: 0 IRQ, 2 SMI, 1 or 3 none |
| preload1_i | input | PRELOAD_W | First stage length in ticks |
| preload2_i | input | PRELOAD_W | Second stage length in ticks |
| kick_i | input | 1 | Keep-alive strobe |
| clr_prev_i | input | 1 | Clears the previous-reboot flag |
| irq_o | output | 1 | Stage-1 interrupt pulse, IRQ type |
| smi_o | output | 1 | Stage-1 interrupt pulse, SMI type |
| reboot_req_o | output | 1 | Reboot request pulse |
| prev_reboot_o | output | 1 | Sticky flag: a reboot request has occurred |
| stage_o | output | 2 | Current stage |

## Verification
The hardest situation to reach is a keep-alive arriving in the very cycle in which a stage would expire, since it only exists for one reference cycle out of each interval. The bench counts clock edges from the enabling control write and raises `kick_i` so that it is sampled on the predicted expiry edge. It then checks that no pulse appears and that the next expiry lands a full interval after the kick. The lock case is also reached only through a chosen sequence: lock together with enable, then try to disable and to set free-run, and show through the stage-2 outcome that neither write took hold.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_DONE = 2'd3
  } wdt_stage_e;

  typedef enum logic [1:0] {
    INT_IRQ  = 2'd0,
    INT_RSVD = 2'd1,
    INT_SMI  = 2'd2,
    INT_OFF  = 2'd3
  } int_sel_e;

  // control word bit positions (software-visible layout)
  localparam int unsigned CW_LOCK = 0;
  localparam int unsigned CW_EN   = 1;
  localparam int unsigned CW_FREE = 2;

endpackage

// File: rtl/wdt2_ctrl.sv
module wdt2_ctrl
  import wdt2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] word_i,
  output logic       en_o,
  output logic       free_o,
  output logic       locked_o,
  output logic       en_set_o,
  output logic       en_clr_o
);

  logic wr_ok;

  assign wr_ok    = wr_i && !locked_o;
  assign en_set_o = wr_ok && word_i[CW_EN] && !en_o;
  assign en_clr_o = wr_ok && !word_i[CW_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      free_o   <= 1'b0;
      locked_o <= 1'b0;
    end else if (wr_ok) begin
      en_o     <= word_i[CW_EN];
      free_o   <= word_i[CW_FREE];
      locked_o <= word_i[CW_LOCK];
    end
  end

endmodule

// File: rtl/wdt2_prescale.sv
module wdt2_prescale #(
  parameter int unsigned FAST_SHIFT = 5,
  parameter int unsigned SLOW_SHIFT = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fast_i,
  output logic tick_o
);

  localparam int unsigned PW = SLOW_SHIFT;
  localparam logic [PW-1:0] FAST_MASK = PW'((64'd1 << FAST_SHIFT) - 64'd1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  assign mask   = fast_i ? FAST_MASK : '1;
  assign tick_o = ((cnt_q | ~mask) == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdt2_stage_count.sv
module wdt2_stage_count #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt      = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign expire_o = tick_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= nxt[W-1:0];
  end

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt2_pkg::*;
#(
  parameter int unsigned PRELOAD_W  = 20,
  parameter int unsigned FAST_SHIFT = 5,
  parameter int unsigned SLOW_SHIFT = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_wr_i,
  input  logic [2:0]           ctl_word_i,
  input  logic                 reboot_off_i,
  input  logic                 fast_i,
  input  logic [1:0]           int_type_i,
  input  logic [PRELOAD_W-1:0] preload1_i,
  input  logic [PRELOAD_W-1:0] preload2_i,
  input  logic                 kick_i,
  input  logic                 clr_prev_i,
  output logic                 irq_o,
  output logic                 smi_o,
  output logic                 reboot_req_o,
  output logic                 prev_reboot_o,
  output logic [1:0]           stage_o
);

  logic ctl_en, ctl_free, ctl_locked, ctl_en_set, ctl_en_clr;
  logic tick, cnt_exp, cnt_clr;
  logic running, kick_ok, start1, fire, fire_two;
  wdt_stage_e stage_q;
  int_sel_e   itype;
  logic [PRELOAD_W-1:0] limit_q;

  wdt2_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctl_wr_i),
    .word_i   (ctl_word_i),
    .en_o     (ctl_en),
    .free_o   (ctl_free),
    .locked_o (ctl_locked),
    .en_set_o (ctl_en_set),
    .en_clr_o (ctl_en_clr)
  );

  wdt2_prescale #(
    .FAST_SHIFT (FAST_SHIFT),
    .SLOW_SHIFT (SLOW_SHIFT)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .fast_i (fast_i),
    .tick_o (tick)
  );

  wdt2_stage_count #(
    .W (PRELOAD_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .tick_i   (tick),
    .limit_i  (limit_q),
    .expire_o (cnt_exp)
  );

  assign itype    = int_sel_e'(int_type_i);
  assign running  = (stage_q == ST_ONE) || (stage_q == ST_TWO);
  assign kick_ok  = kick_i && ctl_en && !ctl_en_clr;
  assign start1   = ctl_en_set || kick_ok;
  assign fire     = cnt_exp && running && !start1 && !ctl_en_clr;
  assign fire_two = fire && (stage_q == ST_TWO);
  assign cnt_clr  = start1 || fire || !running || ctl_en_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q      <= ST_IDLE;
      limit_q      <= '1;
      irq_o        <= 1'b0;
      smi_o        <= 1'b0;
      reboot_req_o <= 1'b0;
    end else begin
      irq_o        <= 1'b0;
      smi_o        <= 1'b0;
      reboot_req_o <= 1'b0;
      if (ctl_en_clr) begin
        stage_q <= ST_IDLE;
      end else if (start1) begin
        stage_q <= ST_ONE;
        limit_q <= preload1_i;
      end else if (!ctl_en) begin
        stage_q <= ST_IDLE;
      end else if (fire && stage_q == ST_ONE) begin
        stage_q <= ST_TWO;
        limit_q <= preload2_i;
        irq_o   <= (itype == INT_IRQ);
        smi_o   <= (itype == INT_SMI);
      end else if (fire_two) begin
        reboot_req_o <= !reboot_off_i;
        stage_q      <= ctl_free ? ST_ONE : ST_DONE;
        limit_q      <= preload1_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        prev_reboot_o <= 1'b0;
    else if (fire_two && !reboot_off_i) prev_reboot_o <= 1'b1;
    else if (clr_prev_i)                prev_reboot_o <= 1'b0;
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       kick_i,
  input logic       ctl_wr_i,
  input logic       clr_prev_i,
  input logic       irq_o,
  input logic       smi_o,
  input logic       reboot_req_o,
  input logic       prev_reboot_o,
  input logic [1:0] stage_o,
  input logic       locked
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |=> !irq_o); // R4
  AST_SMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) smi_o |=> !smi_o); // R4
  AST_INT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(irq_o && smi_o)); // R4
  AST_INT_ENTERS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni) (irq_o || smi_o) |-> stage_o == 2'd2); // R4
  AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) reboot_req_o |=> !reboot_req_o); // R5
  AST_REBOOT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) reboot_req_o |-> prev_reboot_o); // R5
  AST_REBOOT_NEXT_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni) reboot_req_o |-> (stage_o == 2'd1 || stage_o == 2'd3)); // R6
  AST_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) (kick_i && stage_o != 2'd0 && !ctl_wr_i) |=> stage_o == 2'd1); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) (stage_o == 2'd0 && !ctl_wr_i) |=> stage_o == 2'd0); // R7
  AST_KICK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) (kick_i && stage_o != 2'd0 && !ctl_wr_i) |=> (!irq_o && !smi_o && !reboot_req_o)); // R8
  AST_LOCK_KEEPS_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni) (locked && stage_o != 2'd0) |=> stage_o != 2'd0); // R9
  AST_PREV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (prev_reboot_o && !clr_prev_i) |=> prev_reboot_o); // R10

endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .kick_i        (kick_i),
  .ctl_wr_i      (ctl_wr_i),
  .clr_prev_i    (clr_prev_i),
  .irq_o         (irq_o),
  .smi_o         (smi_o),
  .reboot_req_o  (reboot_req_o),
  .prev_reboot_o (prev_reboot_o),
  .stage_o       (stage_o),
  .locked        (ctl_locked)
);

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;

  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_wr;
  logic [2:0]    ctl_word;
  logic          reboot_off;
  logic          fast;
  logic [1:0]    int_type;
  logic [PW-1:0] pre1, pre2;
  logic          kick, clr_prev;
  logic          irq, smi, reboot, prev;
  logic [1:0]    stage;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wdt_two_stage i_wdt_two_stage (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ctl_wr_i      (ctl_wr),
    .ctl_word_i    (ctl_word),
    .reboot_off_i  (reboot_off),
    .fast_i        (fast),
    .int_type_i    (int_type),
    .preload1_i    (pre1),
    .preload2_i    (pre2),
    .kick_i        (kick),
    .clr_prev_i    (clr_prev),
    .irq_o         (irq),
    .smi_o         (smi),
    .reboot_req_o  (reboot),
    .prev_reboot_o (prev),
    .stage_o       (stage)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_word = 3'b000; reboot_off = 1'b0;
    fast = 1'b1; int_type = 2'd0; pre1 = 20'd3; pre2 = 20'd2;
    kick = 1'b0; clr_prev = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic ctl(input logic [2:0] w);
    ctl_word = w; ctl_wr = 1'b1;
    wait_n(1);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 stage", stage, 0);
    chk("R1 irq", irq, 0);
    chk("R1 smi", smi, 0);
    chk("R1 reboot", reboot, 0);
    chk("R1 prev", prev, 0);
  endtask

  task automatic t_basic;
    do_reset();
    ctl(3'b010);
    chk("R2 started", stage, 1);
    wait_n(95);
    chk("R3 no early irq", irq, 0);
    wait_n(1);
    chk("R4 irq pulse", irq, 1);
    chk("R4 no smi", smi, 0);
    chk("R4 stage two", stage, 2);
    wait_n(1);
    chk("R4 irq one cycle", irq, 0);
    wait_n(62);
    chk("R3 no early reboot", reboot, 0);
    wait_n(1);
    chk("R5 reboot pulse", reboot, 1);
    chk("R5 prev set", prev, 1);
    chk("R6 expired", stage, 3);
    wait_n(1);
    chk("R5 reboot one cycle", reboot, 0);
    wait_n(200);
    chk("R6 stays expired", stage, 3);
    ctl(3'b000);
    chk("R2 disabled", stage, 0);
    wait_n(200);
    chk("R2 stays stopped", stage, 0);
    chk("R10 prev held", prev, 1);
    clr_prev = 1'b1;
    wait_n(1);
    clr_prev = 1'b0;
    chk("R10 prev cleared", prev, 0);
  endtask

  task automatic t_types;
    do_reset();
    int_type = 2'd2;
    ctl(3'b010);
    wait_n(96);
    chk("R4 smi pulse", smi, 1);
    chk("R4 smi no irq", irq, 0);
    do_reset();
    int_type = 2'd3;
    ctl(3'b010);
    wait_n(96);
    chk("R4 off no irq", irq, 0);
    chk("R4 off no smi", smi, 0);
    chk("R4 off stage two", stage, 2);
  endtask

  task automatic t_noreboot;
    do_reset();
    reboot_off = 1'b1;
    ctl(3'b010);
    wait_n(160);
    chk("R5 reboot suppressed", reboot, 0);
    chk("R5 prev untouched", prev, 0);
    chk("R6 expired", stage, 3);
  endtask

  task automatic t_freerun;
    do_reset();
    ctl(3'b110);
    wait_n(160);
    chk("R6 free reboot", reboot, 1);
    chk("R6 free restart", stage, 1);
    wait_n(96);
    chk("R6 second irq", irq, 1);
  endtask

  task automatic t_kick;
    do_reset();
    ctl(3'b010);
    wait_n(80);
    kick = 1'b1;
    wait_n(1);
    kick = 1'b0;
    wait_n(15);
    chk("R7 kick avoids irq", irq, 0);
    chk("R7 kick stage one", stage, 1);
    wait_n(80);
    chk("R7 no early irq", irq, 0);
    wait_n(1);
    chk("R7 irq after kick", irq, 1);
    do_reset();
    kick = 1'b1;
    wait_n(1);
    kick = 1'b0;
    wait_n(5);
    chk("R7 kick ignored disabled", stage, 0);
  endtask

  task automatic t_collide;
    do_reset();
    ctl(3'b010);
    wait_n(95);
    kick = 1'b1;
    wait_n(1);
    kick = 1'b0;
    chk("R8 no irq on collision", irq, 0);
    chk("R8 stage one", stage, 1);
    wait_n(95);
    chk("R8 no early irq", irq, 0);
    wait_n(1);
    chk("R8 irq after full interval", irq, 1);
  endtask

  task automatic t_lock;
    do_reset();
    ctl(3'b011);
    wait_n(20);
    ctl(3'b000);
    chk("R9 disable ignored", stage, 1);
    wait_n(74);
    chk("R9 no early irq", irq, 0);
    wait_n(1);
    chk("R9 irq on schedule", irq, 1);
    ctl(3'b110);
    wait_n(63);
    chk("R9 reboot", reboot, 1);
    chk("R9 free-run not taken", stage, 3);
  endtask

  task automatic t_preload;
    do_reset();
    ctl(3'b010);
    wait_n(10);
    pre1 = 20'd1;
    ctl(3'b010);
    wait_n(84);
    chk("R11 no early irq", irq, 0);
    chk("R2 rewrite no restart", stage, 1);
    wait_n(1);
    chk("R11 irq on latched length", irq, 1);
  endtask

  task automatic t_slow;
    do_reset();
    fast = 1'b0;
    pre1 = 20'd1;
    ctl(3'b010);
    wait_n(32767);
    chk("R3 slow no early irq", irq, 0);
    wait_n(1);
    chk("R3 slow irq", irq, 1);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_types();
    t_noreboot();
    t_freerun();
    t_kick();
    t_collide();
    t_lock();
    t_preload();
    t_slow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule